// File: doc/BRIEF.md
# Time-Slot Interchanger with Selectable Latency

This block reorders the byte-wide channels of one time-division stream. A frame carries 32 channels. Each incoming byte goes into a banked data store at the position of its channel. Each outgoing channel position reads the byte from the source channel named in a per-position connection entry. The connection table is loaded through a simple write port. Each entry holds a 5-bit source channel number and an enable flag.

Two latency disciplines are offered. Variable-delay mode delivers a byte as soon as possible, but never sooner than three strobes after it arrived. Pairings closer than that wrap into the next frame. Constant-delay mode keeps frames intact: every byte arriving in frame N leaves in frame N+2, whatever the channel pair. Three data banks rotate once per frame. In variable mode the reader picks between the bank being filled now and the bank filled one frame earlier. In constant mode it reads the bank filled two frames earlier.

Top module: `tsi_top`

## Requirements
- R1: After reset the output byte is 8'hFF, every connection entry is disabled with source 0, all stored bytes are zero, and variable-delay mode is in force.
- R2: A strobe that coincides with the frame pulse is channel 0. Each later strobe is the next channel. The input byte sampled at the strobe of channel k is stored as channel k of the current frame.
- R3: The output register changes only on a strobe. The strobe of channel m loads output channel m, visible from the next clock on.
- R4: In variable mode, when output channel m is at least three above source channel n, output m carries byte n of the same frame.
- R5: In variable mode, when m equals n, n+1 or n+2, output m carries byte n of the previous frame.
- R6: In variable mode, when m is below n, output m carries byte n of the previous frame.
- R7: In constant mode, output m of frame N carries byte n of frame N-2, for every pairing.
- R8: An output channel whose connection entry has the enable flag clear carries 8'hFF.
- R9: The mode input is sampled only at a frame pulse. A change between pulses has no effect on the outputs of the current frame.
- R10: A connection write in the same cycle as the strobe that reads that entry leaves the old entry in use for that strobe. The new entry serves the following strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| slotStb | input | 1 | Channel-rate strobe, one cycle per channel |
| frameStb | input | 1 | Frame start, valid together with slotStb for channel 0 |
| modeConst | input | 1 | 1 selects constant-delay mode, 0 selects variable-delay mode |
| dataIn | input | 8 | Input byte of the current channel |
| cmWrEn | input | 1 | Connection entry write enable |
| cmWrAddr | input | 5 | Output channel whose entry is written |
| cmWrSrc | input | 5 | Source channel for that output |
| cmWrOe | input | 1 | Output enable flag for that channel |
| dataOut | output | 8 | Registered output byte of the current channel |

## Verification
Two functions can act in one cycle: a connection-table write, and the strobe that reads the same entry to build that channel's output. The bench causes this by writing the entry of channel 9 on the very strobe of channel 9, during a constant-mode frame. It expects the byte chosen by the old entry there, and the new source one frame later. A second overlap is a mode change placed in the middle of a frame. The model holds the old mode until the next frame pulse, so an early switch shows up as a mismatch.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  parameter int CH_NUM = 32;
  parameter int DATA_W = 8;
  localparam int SLOT_W = $clog2(CH_NUM);
  localparam int NBANK  = 3;
  localparam int BANK_W = 2;
  localparam int MIN_GAP = 3;

  typedef struct packed {
    logic              stb;
    logic [SLOT_W-1:0] slot;
    logic [BANK_W-1:0] wrBank;
    logic [BANK_W-1:0] prevBank;
    logic [BANK_W-1:0] oldBank;
    logic              constMode;
  } tsiCtl_t;
endpackage

// File: rtl/tsi_ctrl.sv
module tsi_ctrl
  import tsi_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    slotStb,
  input  logic    frameStb,
  input  logic    modeConst,
  output tsiCtl_t ctl
);
  logic [SLOT_W-1:0] slotCnt, nextSlot;
  logic [BANK_W-1:0] wBank, nextBank;
  logic              modeReg, nextMode, pulse;

  function automatic logic [BANK_W-1:0] bankInc(input logic [BANK_W-1:0] b);
    return (b == BANK_W'(NBANK-1)) ? '0 : b + 1'b1;
  endfunction

  function automatic logic [BANK_W-1:0] bankDec(input logic [BANK_W-1:0] b);
    return (b == '0) ? BANK_W'(NBANK-1) : b - 1'b1;
  endfunction

  always_comb begin
    pulse    = slotStb && frameStb;
    nextSlot = pulse ? '0 : slotCnt + 1'b1;
    nextBank = pulse ? bankInc(wBank) : wBank;
    nextMode = pulse ? modeConst : modeReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotCnt <= SLOT_W'(CH_NUM-1);
      wBank   <= '0;
      modeReg <= 1'b0;
    end else if (slotStb) begin
      slotCnt <= nextSlot;
      wBank   <= nextBank;
      modeReg <= nextMode;
    end
  end

  always_comb begin
    ctl.stb       = slotStb;
    ctl.slot      = nextSlot;
    ctl.wrBank    = nextBank;
    ctl.prevBank  = bankDec(nextBank);
    ctl.oldBank   = bankInc(nextBank);
    ctl.constMode = nextMode;
  end

  // R2
  frame_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotStb && frameStb) |=> (slotCnt == '0));
  // R9
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(slotStb && frameStb) |=> $stable(modeReg));
  // R7
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(slotStb && frameStb) |=> $stable(wBank));
endmodule

// File: rtl/tsi_datapath.sv
module tsi_datapath
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tsiCtl_t           ctl,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cmWrEn,
  input  logic [SLOT_W-1:0] cmWrAddr,
  input  logic [SLOT_W-1:0] cmWrSrc,
  input  logic              cmWrOe,
  output logic [DATA_W-1:0] dataOut
);
  logic [SLOT_W-1:0] cmSrc [CH_NUM];
  logic              cmOe  [CH_NUM];
  logic [NBANK-1:0][DATA_W-1:0] bankRd;
  logic [SLOT_W-1:0] src;
  logic              useCur, selOe;
  logic [BANK_W-1:0] rdBank;
  logic [DATA_W-1:0] rdByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < CH_NUM; i++) begin
        cmSrc[i] <= '0;
        cmOe[i]  <= 1'b0;
      end
    end else if (cmWrEn) begin
      cmSrc[cmWrAddr] <= cmWrSrc;
      cmOe[cmWrAddr]  <= cmWrOe;
    end
  end

  always_comb begin
    src    = cmSrc[ctl.slot];
    selOe  = cmOe[ctl.slot];
    useCur = ({1'b0, src} + (SLOT_W+1)'(MIN_GAP)) <= {1'b0, ctl.slot};
    if (ctl.constMode)  rdBank = ctl.oldBank;
    else if (useCur)    rdBank = ctl.wrBank;
    else                rdBank = ctl.prevBank;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [DATA_W-1:0] bankMem [CH_NUM];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        for (int i = 0; i < CH_NUM; i++) bankMem[i] <= '0;
      end else if (ctl.stb && ctl.wrBank == BANK_W'(b)) begin
        bankMem[ctl.slot] <= dataIn;
      end
    end
    assign bankRd[b] = bankMem[src];
  end

  always_comb begin
    rdByte = '1;
    for (int b = 0; b < NBANK; b++)
      if (rdBank == BANK_W'(b)) rdByte = bankRd[b];
  end

  always_ff @(posedge clk) begin
    if (!rstN)        dataOut <= '1;
    else if (ctl.stb) dataOut <= selOe ? rdByte : '1;
  end

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.stb |=> $stable(dataOut));
  // R8
  out_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stb && !selOe) |=> (dataOut == '1));
  // R7
  bank_apart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stb && ctl.constMode) |-> (rdBank != ctl.wrBank));
  // R5
  near_prev_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.stb && !ctl.constMode && src <= ctl.slot &&
     ({1'b0, ctl.slot} - {1'b0, src}) < (SLOT_W+1)'(MIN_GAP)) |-> (rdBank == ctl.prevBank));
endmodule

// File: rtl/tsi_top.sv
module tsi_top
  import tsi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              slotStb,
  input  logic              frameStb,
  input  logic              modeConst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              cmWrEn,
  input  logic [SLOT_W-1:0] cmWrAddr,
  input  logic [SLOT_W-1:0] cmWrSrc,
  input  logic              cmWrOe,
  output logic [DATA_W-1:0] dataOut
);
  tsiCtl_t ctl;

  tsi_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .frameStb(frameStb),
    .modeConst(modeConst), .ctl(ctl)
  );

  tsi_datapath u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .dataIn(dataIn),
    .cmWrEn(cmWrEn), .cmWrAddr(cmWrAddr), .cmWrSrc(cmWrSrc), .cmWrOe(cmWrOe),
    .dataOut(dataOut)
  );
endmodule

// File: tb/tsi_top_test.sv
`timescale 1ns/1ps
module tsi_top_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       slotStb = 1'b0, frameStb = 1'b0, modeConst = 1'b0;
  logic [7:0] dataIn = '0;
  logic       cmWrEn = 1'b0, cmWrOe = 1'b0;
  logic [4:0] cmWrAddr = '0, cmWrSrc = '0;
  logic [7:0] dataOut;

  int totalCnt = 0, failCnt = 0;
  bit done = 0;
  int hist [int];
  int mCm [32];
  bit mOe [32];
  int expOut = 255;
  int slot = 31, frame = -1;
  bit mMode = 0;
  int r9Frame = -100;

  always #4 clk = ~clk;

  tsi_top uut (
    .clk(clk), .rstN(rstN), .slotStb(slotStb), .frameStb(frameStb),
    .modeConst(modeConst), .dataIn(dataIn), .cmWrEn(cmWrEn),
    .cmWrAddr(cmWrAddr), .cmWrSrc(cmWrSrc), .cmWrOe(cmWrOe), .dataOut(dataOut)
  );

  function automatic int rd(input int f, input int c);
    return hist.exists(f*32+c) ? hist[f*32+c] : 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s: dataOut=%02h expected %02h (frame %0d slot %0d)", tag, act, exp, frame, slot);
    end
  endtask

  task automatic step(input bit stb, input bit fp, input int din,
                      input bit we, input int wa, input int ws, input bit wo);
    string tag = "R3";
    slotStb = stb; frameStb = fp; dataIn = 8'(din);
    cmWrEn = we; cmWrAddr = 5'(wa); cmWrSrc = 5'(ws); cmWrOe = wo;
    @(posedge clk);
    if (stb) begin
      int s;
      if (fp) begin slot = 0; frame++; mMode = modeConst; end
      else slot = (slot + 1) % 32;
      s = mCm[slot];
      if (!mOe[slot])          begin expOut = 255;               tag = "R8"; end
      else if (mMode)          begin expOut = rd(frame-2, s);    tag = "R7"; end
      else if (s + 3 <= slot)  begin expOut = rd(frame, s);      tag = "R4"; end
      else if (s <= slot)      begin expOut = rd(frame-1, s);    tag = "R5"; end
      else                     begin expOut = rd(frame-1, s);    tag = "R6"; end
      if (fp && tag != "R8") tag = "R2";
      if (frame == r9Frame) tag = "R9";
      if (we && wa == slot) tag = "R10";
      hist[frame*32+slot] = din & 255;
    end
    if (we) begin mCm[wa] = ws; mOe[wa] = wo; end
    @(negedge clk);
    #1;
    check(dataOut == 8'(expOut), tag, dataOut, expOut);
  endtask

  task automatic runFrame(input int base, input int gap, input int modeAt, input bit modeVal,
                          input int collideAt, input int newSrc);
    for (int ch = 0; ch < 32; ch++) begin
      if (ch == modeAt) begin modeConst = modeVal; r9Frame = frame + 1; end
      if (ch == collideAt) step(1, ch == 0, base + ch*13, 1, ch, newSrc, 1);
      else                 step(1, ch == 0, base + ch*13, 0, 0, 0, 0);
      for (int g = 1; g < gap; g++) step(0, 0, 8'hA5, 0, 0, 0, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin mCm[i] = 0; mOe[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    check(dataOut == 8'hFF, "R1", dataOut, 255);
    rstN = 1'b1;
    // R1: disabled entries right after reset give all ones, stored zeros elsewhere
    step(0, 0, 0, 0, 0, 0, 0);
    for (int m = 0; m < 32; m++) step(0, 0, 0, 1, m, (m*7+3) % 32, m != 5);
    step(0, 0, 0, 1, 10, 7, 1);   // R4 pair
    step(0, 0, 0, 1, 12, 12, 1);  // R5 same channel
    step(0, 0, 0, 1, 13, 12, 1);  // R5 one later
    step(0, 0, 0, 1, 14, 12, 1);  // R5 two later
    step(0, 0, 0, 1, 15, 12, 1);  // R4 three later
    step(0, 0, 0, 1, 2, 30, 1);   // R6 wrap
    runFrame(8'h10, 2, -1, 0, -1, 0);
    runFrame(8'h40, 3, -1, 0, -1, 0);
    runFrame(8'h70, 2, 20, 1, -1, 0);   // R9: mode switch mid-frame
    runFrame(8'h90, 2, -1, 1, -1, 0);
    runFrame(8'hB3, 2, -1, 1, 9, 31);   // R10 collision
    runFrame(8'hC7, 3, 11, 0, -1, 0);   // R9: switch back
    runFrame(8'hE1, 2, -1, 0, -1, 0);
    runFrame(8'h05, 2, -1, 0, -1, 0);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      totalCnt++; failCnt++;
      $display("FAIL watchdog: dataOut=%02h expected run end", dataOut);
      $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
      $finish;
    end
  end
endmodule